// File: doc/BRIEF.md
# Streaming Raster Resampler with Selectable Bilinear or Nearest-Neighbour Filter

This block converts a raster stream of RGB888 pixels from one picture size to another. The caller presents the source width and height and the target width and height on plain inputs. The block works out the horizontal and vertical step sizes on its own, once per frame. The two axes are independent, so one axis can shrink while the other grows, and ratios need not be whole numbers. A single select bit picks either 2x2 bilinear blending or nearest-neighbour picking.

Source pixels arrive in raster order through a valid/ready handshake. The first pixel of a frame carries a start-of-frame flag. Two source rows are held in on-chip line memory. When the output side still needs both stored rows, the block deasserts its input ready until one of those rows is no longer referenced. Result pixels leave through a second valid/ready handshake. The first result pixel of each frame carries its own start flag.

Top module: `video_scaler`

## Requirements
- R1: `alg_nearest` is sampled when a frame starts: 0 gives bilinear blending and 1 gives nearest-neighbour picking for the whole of that frame.
- R2: A source pixel is taken only on a clock edge where `in_valid` and `in_ready` are both high. After reset, with no start flag presented, `in_ready` is high and `out_valid` is low.
- R3: A result pixel moves only on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_pix` and `out_sof` do not change.
- R4: For each axis, the step is floor(source_size * 65536 / target_size), computed by a sequential divider after the start flag is seen. No source pixel is taken and no result is offered for at least SIZE_W+FRAC_W cycles while the divider runs. Result k on an axis uses source coordinate k*step, in 16.16 fixed point.
- R5: In nearest-neighbour mode, each result equals the source pixel at the integer parts of the two coordinates.
- R6: In bilinear mode, each 8-bit channel (red [23:16], green [15:8], blue [7:0]) is blended separately over the 2x2 neighbourhood. The weights are the top 8 fraction bits fx and fy, and the right and lower neighbours clamp to the last column and row. The horizontal blends are top = a*(256-fx)+b*fx and bot = c*(256-fx)+d*fx. The result is (top*(256-fy)+bot*fy+32768)>>16, saturated to 255.
- R7: When the target size equals the source size, every result equals its source pixel bit for bit, in both modes.
- R8: During enlargement, the block lowers `in_ready` for a pixel from source row r while it still needs row r-2. No result is formed from a row that has not been fully received.
- R9: Each frame yields exactly target_width*target_height results in raster order, and only the first one has `out_sof` set. After the frame, no further result is offered until a new frame starts.
- R10: While idle, source pixels without the start flag are accepted and discarded. They affect no later result.
- R11: When shrinking, source rows left over after the last result are still accepted and dropped, so the source can finish its frame.
- R12: The horizontal and vertical ratios are independent. One axis may shrink while the other grows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alg_nearest | input | 1 | Filter select: 0 bilinear, 1 nearest-neighbour |
| src_w | input | SIZE_W | Source width in pixels |
| src_h | input | SIZE_W | Source height in rows |
| dst_w | input | SIZE_W | Target width in pixels |
| dst_h | input | SIZE_W | Target height in rows |
| in_valid | input | 1 | Source pixel present |
| in_ready | output | 1 | Block can take the source pixel |
| in_sof | input | 1 | Source pixel is the first of a frame |
| in_pix | input | 24 | Source pixel, RGB888 |
| out_valid | output | 1 | Result pixel present |
| out_ready | input | 1 | Downstream can take the result |
| out_sof | output | 1 | Result is the first of a frame |
| out_pix | output | 24 | Result pixel, RGB888 |

## Verification
Same-size frames in both modes must reproduce the source exactly, which separates a correct zero-weight path from one with rounding or off-by-one coordinate errors. Shrinking frames test truncated step sums and the dropping of leftover rows. Enlarging frames exercise edge clamping and the input stall. Mixed-ratio frames (one axis shrinking, the other growing) and random sizes with random handshake gaps catch axis mix-ups and bank-selection errors. Leading pixels without a start flag, sent while idle, must leave no trace in the frame that follows.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
   localparam int CH_W = 8;
   localparam int CH_N = 3;
   localparam int PIX_W = CH_W * CH_N;

   typedef logic [PIX_W-1:0] pix_t;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_DIV  = 2'd1,
      FS_RUN  = 2'd2
   } frame_st_t;

   typedef enum logic [1:0] {
      OS_ISS = 2'd0,
      OS_RD  = 2'd1,
      OS_OUT = 2'd2
   } out_st_t;
endpackage

// File: rtl/scaler_div.sv
module scaler_div #(
   parameter int N_W = 27,
   parameter int D_W = 11
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N_W-1:0] num,
   input  logic [D_W-1:0] den,
   output logic           busy,
   output logic [N_W-1:0] quo
);
   localparam int CW = $clog2(N_W + 1);
   localparam int PW = N_W + D_W + 1;

   if (N_W < 2) begin : g_bad_nw
      $error("scaler_div: N_W must be at least 2");
   end

   logic [N_W-1:0] q_r, num_r;
   logic [D_W-1:0] rem_r, den_r;
   logic [CW-1:0]  cnt_r;
   logic           busy_r;
   logic [D_W:0]   trial, diff;
   logic           geq;

   always_comb begin
      trial = {rem_r, q_r[N_W-1]};
      geq   = trial >= {1'b0, den_r};
      diff  = trial - {1'b0, den_r};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         num_r  <= '0;
         rem_r  <= '0;
         den_r  <= '0;
         cnt_r  <= '0;
         busy_r <= 1'b0;
      end else if (start) begin
         q_r    <= num;
         num_r  <= num;
         den_r  <= den;
         rem_r  <= '0;
         cnt_r  <= CW'(N_W);
         busy_r <= 1'b1;
      end else if (busy_r) begin
         rem_r <= geq ? diff[D_W-1:0] : trial[D_W-1:0];
         q_r   <= {q_r[N_W-2:0], geq};
         cnt_r <= cnt_r - 1'b1;
         if (cnt_r == CW'(1)) busy_r <= 1'b0;
      end
   end

   assign busy = busy_r;
   assign quo  = q_r;

   // R4: the finished quotient is the floor of num/den
   assert_step_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_r) && den_r != '0) |->
         ((PW'(q_r) * PW'(den_r) <= PW'(num_r)) &&
          ((PW'(q_r) + PW'(1)) * PW'(den_r) > PW'(num_r))));
endmodule

// File: rtl/scaler_linebuf.sv
module scaler_linebuf #(
   parameter int DEPTH = 1280,
   parameter int DW    = 24,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          wbank,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          bank_a,
   input  logic          bank_b,
   input  logic [AW-1:0] raddr_l,
   input  logic [AW-1:0] raddr_r,
   output logic [DW-1:0] a_l,
   output logic [DW-1:0] a_r,
   output logic [DW-1:0] b_l,
   output logic [DW-1:0] b_r
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("scaler_linebuf: DEPTH must be at least 2");
   end

   logic sel_a_q, sel_b_q;

   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] ql, qr;
      always_ff @(posedge clk) begin
         if (we && (wbank == 1'(g))) mem[waddr] <= wdata;
         ql <= mem[raddr_l];
         qr <= mem[raddr_r];
      end
   end

   always_ff @(posedge clk) begin
      sel_a_q <= bank_a;
      sel_b_q <= bank_b;
   end

   assign a_l = sel_a_q ? g_bank[1].ql : g_bank[0].ql;
   assign a_r = sel_a_q ? g_bank[1].qr : g_bank[0].qr;
   assign b_l = sel_b_q ? g_bank[1].ql : g_bank[0].ql;
   assign b_r = sel_b_q ? g_bank[1].qr : g_bank[0].qr;

   // R8: writes land inside the row storage
   assert_wr_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/scaler_blend.sv
module scaler_blend #(
   parameter int CH_W = 8,
   parameter int CH_N = 3,
   parameter int WT_W = 8,
   localparam int PW  = CH_W * CH_N
)(
   input  logic            nearest,
   input  logic [WT_W-1:0] fx,
   input  logic [WT_W-1:0] fy,
   input  logic [PW-1:0]   p00,
   input  logic [PW-1:0]   p01,
   input  logic [PW-1:0]   p10,
   input  logic [PW-1:0]   p11,
   output logic [PW-1:0]   pix
);
   localparam int H_W  = CH_W + WT_W + 1;
   localparam int V_W  = H_W + WT_W + 1;
   localparam int ONE  = 1 << WT_W;
   localparam int HALF = 1 << (2 * WT_W - 1);
   localparam int MAXV = (1 << CH_W) - 1;

   if (WT_W < 1 || CH_W < 1) begin : g_bad_w
      $error("scaler_blend: widths must be positive");
   end

   logic [WT_W:0] wx0, wx1, wy0, wy1;
   assign wx1 = (WT_W+1)'(ONE) - {1'b0, fx};
   assign wx0 = {1'b0, fx};
   assign wy1 = (WT_W+1)'(ONE) - {1'b0, fy};
   assign wy0 = {1'b0, fy};

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic [CH_W-1:0] a, b, d0, d1;
      logic [H_W-1:0]  top, bot;
      logic [V_W-1:0]  v, shr;
      logic [CH_W-1:0] res;
      always_comb begin
         a   = p00[c*CH_W +: CH_W];
         b   = p01[c*CH_W +: CH_W];
         d0  = p10[c*CH_W +: CH_W];
         d1  = p11[c*CH_W +: CH_W];
         top = H_W'(a)  * H_W'(wx1) + H_W'(b)  * H_W'(wx0);
         bot = H_W'(d0) * H_W'(wx1) + H_W'(d1) * H_W'(wx0);
         v   = V_W'(top) * V_W'(wy1) + V_W'(bot) * V_W'(wy0) + V_W'(HALF);
         shr = v >> (2 * WT_W);
         res = (shr > V_W'(MAXV)) ? CH_W'(MAXV) : shr[CH_W-1:0];
      end
      assign pix[c*CH_W +: CH_W] = nearest ? a : res;
   end
endmodule

// File: rtl/video_scaler.sv
module video_scaler
   import scaler_pkg::*;
#(
   parameter int SIZE_W = 11,
   parameter int MAX_W  = 1280,
   parameter int FRAC_W = 16,
   parameter int WT_W   = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alg_nearest,
   input  logic [SIZE_W-1:0] src_w,
   input  logic [SIZE_W-1:0] src_h,
   input  logic [SIZE_W-1:0] dst_w,
   input  logic [SIZE_W-1:0] dst_h,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sof,
   input  logic [23:0]       in_pix,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_sof,
   output logic [23:0]       out_pix
);
   localparam int N_W   = SIZE_W + FRAC_W;
   localparam int ACC_W = N_W + 1;
   localparam int AW    = $clog2(MAX_W);

   if (MAX_W > (1 << SIZE_W)) begin : g_bad_maxw
      $error("video_scaler: MAX_W exceeds the size field range");
   end
   if (WT_W > FRAC_W) begin : g_bad_wt
      $error("video_scaler: weight bits exceed fraction bits");
   end
   if (PIX_W != 24) begin : g_bad_pix
      $error("video_scaler: pixel must be 24 bits");
   end

   frame_st_t fst;
   out_st_t   ost;

   logic [SIZE_W-1:0] sw_q, sh_q, dw_q, dh_q;
   logic              near_q;
   logic [N_W-1:0]    step_x, step_y, qx, qy;
   logic              busy_x, busy_y, start_div;

   logic [SIZE_W-1:0] col_in, row_in, col_o, row_o;
   logic [SIZE_W:0]   rows_done;
   logic              in_done, out_done;
   logic [ACC_W-1:0]  xacc, yacc;

   logic [SIZE_W:0]   xi, yi, x0, x1, y0, y1, wlast, hlast;
   logic              in_fire, wr_en;
   pix_t              a_l, a_r, b_l, b_r, blend_pix;
   logic              out_valid_q, out_sof_q;
   pix_t              out_pix_q;

   // frame-start step computation, one divider per axis
   assign start_div = (fst == FS_IDLE) && in_valid && in_sof;

   scaler_div #(.N_W(N_W), .D_W(SIZE_W)) u_div_x (
      .clk(clk), .rst_n(rst_n), .start(start_div),
      .num({src_w, {FRAC_W{1'b0}}}), .den(dst_w),
      .busy(busy_x), .quo(qx));

   scaler_div #(.N_W(N_W), .D_W(SIZE_W)) u_div_y (
      .clk(clk), .rst_n(rst_n), .start(start_div),
      .num({src_h, {FRAC_W{1'b0}}}), .den(dst_h),
      .busy(busy_y), .quo(qy));

   // source coordinates with edge clamping
   always_comb begin
      wlast = {1'b0, sw_q} - 1'b1;
      hlast = {1'b0, sh_q} - 1'b1;
      xi    = xacc[ACC_W-1:FRAC_W];
      yi    = yacc[ACC_W-1:FRAC_W];
      x0    = (xi > wlast) ? wlast : xi;
      y0    = (yi > hlast) ? hlast : yi;
      x1    = (x0 < wlast) ? x0 + 1'b1 : wlast;
      y1    = (y0 < hlast) ? y0 + 1'b1 : hlast;
   end

   // input acceptance: idle drops stray pixels, run stalls on row reuse
   always_comb begin
      unique case (fst)
         FS_IDLE: in_ready = !in_sof;
         FS_RUN:  in_ready = !in_done &&
                             (out_done || ({1'b0, row_in} <= y0 + 1'b1));
         default: in_ready = 1'b0;
      endcase
   end

   assign in_fire = in_valid && in_ready;
   assign wr_en   = in_fire && (fst == FS_RUN) && (int'(col_in) < MAX_W);

   scaler_linebuf #(.DEPTH(MAX_W), .DW(PIX_W)) u_lines (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en), .wbank(row_in[0]), .waddr(col_in[AW-1:0]), .wdata(in_pix),
      .bank_a(y0[0]), .bank_b(y1[0]),
      .raddr_l(x0[AW-1:0]), .raddr_r(x1[AW-1:0]),
      .a_l(a_l), .a_r(a_r), .b_l(b_l), .b_r(b_r));

   scaler_blend #(.CH_W(CH_W), .CH_N(CH_N), .WT_W(WT_W)) u_blend (
      .nearest(near_q),
      .fx(xacc[FRAC_W-1 -: WT_W]), .fy(yacc[FRAC_W-1 -: WT_W]),
      .p00(a_l), .p01(a_r), .p10(b_l), .p11(b_r),
      .pix(blend_pix));

   // frame control and source-side counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fst       <= FS_IDLE;
         sw_q      <= '0;
         sh_q      <= '0;
         dw_q      <= '0;
         dh_q      <= '0;
         near_q    <= 1'b0;
         step_x    <= '0;
         step_y    <= '0;
         col_in    <= '0;
         row_in    <= '0;
         rows_done <= '0;
         in_done   <= 1'b0;
      end else begin
         unique case (fst)
            FS_IDLE: if (start_div) begin
               sw_q   <= src_w;
               sh_q   <= src_h;
               dw_q   <= dst_w;
               dh_q   <= dst_h;
               near_q <= alg_nearest;
               fst    <= FS_DIV;
            end
            FS_DIV: if (!busy_x && !busy_y) begin
               step_x    <= qx;
               step_y    <= qy;
               col_in    <= '0;
               row_in    <= '0;
               rows_done <= '0;
               in_done   <= 1'b0;
               fst       <= FS_RUN;
            end
            FS_RUN: begin
               if (in_fire) begin
                  if (col_in == sw_q - 1'b1) begin
                     col_in    <= '0;
                     row_in    <= row_in + 1'b1;
                     rows_done <= rows_done + 1'b1;
                     if (row_in == sh_q - 1'b1) in_done <= 1'b1;
                  end else begin
                     col_in <= col_in + 1'b1;
                  end
               end
               if (in_done && out_done) fst <= FS_IDLE;
            end
            default: fst <= FS_IDLE;
         endcase
      end
   end

   // result side: issue read, blend, hold until taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ost         <= OS_ISS;
         col_o       <= '0;
         row_o       <= '0;
         xacc        <= '0;
         yacc        <= '0;
         out_done    <= 1'b0;
         out_valid_q <= 1'b0;
         out_sof_q   <= 1'b0;
         out_pix_q   <= '0;
      end else if (fst != FS_RUN) begin
         ost         <= OS_ISS;
         col_o       <= '0;
         row_o       <= '0;
         xacc        <= '0;
         yacc        <= '0;
         out_done    <= 1'b0;
         out_valid_q <= 1'b0;
      end else begin
         unique case (ost)
            OS_ISS: if (!out_done && (rows_done > y1)) ost <= OS_RD;
            OS_RD: begin
               out_pix_q   <= blend_pix;
               out_sof_q   <= (col_o == '0) && (row_o == '0);
               out_valid_q <= 1'b1;
               ost         <= OS_OUT;
            end
            OS_OUT: if (out_ready) begin
               out_valid_q <= 1'b0;
               ost         <= OS_ISS;
               if (col_o == dw_q - 1'b1) begin
                  col_o <= '0;
                  xacc  <= '0;
                  yacc  <= yacc + ACC_W'(step_y);
                  if (row_o == dh_q - 1'b1) out_done <= 1'b1;
                  else                       row_o    <= row_o + 1'b1;
               end else begin
                  col_o <= col_o + 1'b1;
                  xacc  <= xacc + ACC_W'(step_x);
               end
            end
            default: ost <= OS_ISS;
         endcase
      end
   end

   assign out_valid = out_valid_q;
   assign out_sof   = out_sof_q;
   assign out_pix   = out_pix_q;

   // R3: a stalled result holds
   assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof)));

   // R4: nothing offered outside the running phase
   assert_no_out_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fst != FS_RUN) |-> !out_valid);

   // R8: a blend only reads rows that have fully arrived
   assert_rows_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ost == OS_RD) |-> (rows_done > y1));

   // R9: the source row count matches the frame height when input completes
   assert_in_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_done) |-> (rows_done == {1'b0, sh_q}));
endmodule

// File: tb/tb_video_scaler.sv
module tb_video_scaler;
   localparam int SIZE_W = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alg_nearest = 1'b0;
   logic [SIZE_W-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
   logic              in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
   logic [23:0]       in_pix = '0;
   logic              in_ready, out_valid, out_sof;
   logic [23:0]       out_pix;

   video_scaler dut (
      .clk(clk), .rst_n(rst_n), .alg_nearest(alg_nearest),
      .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
      .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_pix(in_pix),
      .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof), .out_pix(out_pix));

   always #10 clk = ~clk;

   int  img [0:15][0:15];
   int  nchk = 0, nfail = 0;
   bit  finished = 1'b0;
   bit  saw_bp;
   int  first_wait;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   function automatic int ref_pix(input int mode, input int sw, input int sh,
                                  input int dw, input int dh, input int col, input int row);
      int sx, sy, x0, x1, y0, y1, fx, fy, r;
      sx = col * ((sw << 16) / dw);
      sy = row * ((sh << 16) / dh);
      x0 = sx >> 16; if (x0 > sw - 1) x0 = sw - 1;
      y0 = sy >> 16; if (y0 > sh - 1) y0 = sh - 1;
      x1 = (x0 < sw - 1) ? x0 + 1 : sw - 1;
      y1 = (y0 < sh - 1) ? y0 + 1 : sh - 1;
      fx = (sx >> 8) & 255;
      fy = (sy >> 8) & 255;
      if (mode == 1) return img[y0][x0];
      r = 0;
      for (int c = 0; c < 3; c++) begin
         int a, b, d0, d1, top, bot, v;
         a  = (img[y0][x0] >> (8*c)) & 255;
         b  = (img[y0][x1] >> (8*c)) & 255;
         d0 = (img[y1][x0] >> (8*c)) & 255;
         d1 = (img[y1][x1] >> (8*c)) & 255;
         top = a * (256 - fx) + b * fx;
         bot = d0 * (256 - fx) + d1 * fx;
         v = (top * (256 - fy) + bot * fy + 32768) >> 16;
         if (v > 255) v = 255;
         r = r | (v << (8*c));
      end
      return r;
   endfunction

   task automatic produce(input int sw, input int sh, input int gap);
      first_wait = 0;
      for (int r = 0; r < sh; r++) begin
         for (int c = 0; c < sw; c++) begin
            bit sent = 1'b0;
            while (!sent) begin
               @(negedge clk);
               if ((r + c) != 0 && int'($urandom % 100) < gap) begin
                  in_valid = 1'b0;
               end else begin
                  in_valid = 1'b1;
                  in_sof   = (r == 0 && c == 0);
                  in_pix   = img[r][c][23:0];
                  #1;
                  if (in_ready) sent = 1'b1;
                  else if (r == 0 && c == 0) first_wait++;
                  else saw_bp = 1'b1;
               end
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
   endtask

   task automatic consume(input int mode, input int sw, input int sh,
                          input int dw, input int dh, input int stall, input string tag);
      int got = 0;
      bit held = 1'b0;
      logic [23:0] held_pix = '0;
      while (got < dw * dh) begin
         @(negedge clk);
         out_ready = (int'($urandom % 100) >= stall);
         #1;
         if (held && out_valid)
            check(out_pix == held_pix, "R3", "stalled result changed", out_pix, held_pix);
         held = 1'b0;
         if (out_valid && out_ready) begin
            int col = got % dw, row = got / dw, exp;
            exp = (sw == dw && sh == dh) ? img[row][col] : ref_pix(mode, sw, sh, dw, dh, col, row);
            check(out_pix == exp[23:0], tag, $sformatf("pixel (%0d,%0d)", col, row), out_pix, exp);
            check(out_sof == (got == 0), "R9", "start flag", out_sof, got == 0);
            got++;
         end else if (out_valid) begin
            held = 1'b1;
            held_pix = out_pix;
         end
      end
      @(negedge clk);
      out_ready = 1'b1;
   endtask

   task automatic run_frame(input int mode, input int sw, input int sh, input int dw,
                            input int dh, input int gap, input int stall, input string tag);
      for (int r = 0; r < sh; r++)
         for (int c = 0; c < sw; c++)
            img[r][c] = int'($urandom & 32'hFFFFFF);
      img[0][0] = 24'hFFFFFF;
      img[sh-1][sw-1] = 0;
      @(negedge clk);
      alg_nearest = mode[0];
      src_w = SIZE_W'(sw); src_h = SIZE_W'(sh);
      dst_w = SIZE_W'(dw); dst_h = SIZE_W'(dh);
      saw_bp = 1'b0;
      fork
         produce(sw, sh, gap);
         consume(mode, sw, sh, dw, dh, stall, tag);
      join
      check(first_wait >= SIZE_W + 16 && first_wait <= SIZE_W + 24, "R4",
            "start-of-frame wait cycles", first_wait, SIZE_W + 16);
      // R9 / R11: after the frame, no extra result appears
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); #1;
         if (out_valid) check(1'b0, "R9", "extra result after frame", 1, 0);
      end
      check(!out_valid, "R9", "idle after frame", out_valid, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "WATCHDOG", "run did not end", 0, 1);
      report();
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!out_valid, "R2", "out_valid after reset", out_valid, 0);
      check(in_ready, "R2", "in_ready after reset", in_ready, 1);

      // R10: stray pixels while idle are taken and dropped
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sof = 1'b0; in_pix = 24'h123456 + 24'(i);
         #1;
         check(in_ready, "R10", "stray pixel accepted", in_ready, 1);
         check(!out_valid, "R10", "no result from stray pixel", out_valid, 0);
      end
      @(negedge clk); in_valid = 1'b0;
      out_ready = 1'b1;

      run_frame(0, 8, 6, 8, 6, 30, 30, "R7");    // same size, bilinear
      run_frame(1, 8, 6, 8, 6, 20, 40, "R7");    // same size, nearest
      run_frame(0, 12, 8, 5, 3, 10, 20, "R6");   // shrink R11
      run_frame(1, 12, 8, 5, 3, 10, 20, "R5");   // shrink R11
      run_frame(0, 6, 4, 13, 9, 0, 10, "R6");    // enlarge
      check(saw_bp, "R8", "input stalled while enlarging", saw_bp, 1);
      run_frame(1, 6, 4, 13, 9, 0, 10, "R5");
      check(saw_bp, "R8", "input stalled while enlarging", saw_bp, 1);
      run_frame(1, 6, 4, 3, 9, 20, 20, "R12");   // mixed ratios, nearest
      run_frame(0, 5, 4, 11, 2, 20, 20, "R12");  // mixed ratios, bilinear
      run_frame(0, 7, 7, 7, 7, 50, 50, "R1");    // same image shape, both modes
      run_frame(1, 7, 7, 3, 5, 50, 50, "R1");
      for (int k = 0; k < 6; k++) begin
         int m = int'($urandom % 2);
         run_frame(m, 2 + int'($urandom % 15), 2 + int'($urandom % 11),
                   1 + int'($urandom % 20), 1 + int'($urandom % 20),
                   int'($urandom % 40), int'($urandom % 40), m == 1 ? "R5" : "R6");
      end
      report();
   end
endmodule